// File: doc/BRIEF.md
# Up/Down Pulse Counter with Control and Status Byte

This block counts low-to-high transitions on an external count input. The count is held in a register whose width is a parameter, 32 bits by default. A separate direction input selects whether each counted edge adds one or subtracts one. Both field inputs are asynchronous to the system clock, so they pass through a synchroniser. A registered edge detector then turns each rising edge into a single-cycle count strobe.

A host drives the block through an 8-bit control byte and a preset word, and reads back an 8-bit status byte and the live count. Through the control byte the host can do three things:
- load the preset into the counter and hold it there;
- freeze counting;
- drive two auxiliary outputs.

The status byte confirms the load and freeze states, echoes the auxiliary outputs and shows the synchronised levels of the two field inputs. A typical load sequence has four steps. The host raises the set bit with the preset on the data word, then waits for the load acknowledge in the status byte. It then drops the set bit, and counting resumes from the preset.

A parameter selects an inverted-direction variant for field wiring in which a high direction level means counting down.

Top module: `pulse_counter`

## Requirements
- R1: While rst_ni is low, count_o, status_o and aux_o are all zero.
- R2: With the direction level high and neither ctrl_i bit 5 nor bit 4 set, each low-to-high transition of cnt_in_i increments count_o by exactly one. The change appears within six clock edges of the rise. A level held high produces no further counts.
- R3: With the direction level low, each rising edge decrements count_o by one, and 0x00000000 wraps to 0xFFFFFFFF.
- R4: Counting up from 0xFFFFFFFF wraps to 0x00000000.
- R5: While ctrl_i bit 5 (set) is high, each clock edge loads preset_i into count_o and status_o bit 5 reads 1. Count edges are ignored for as long as bit 5 stays high.
- R6: While ctrl_i bit 4 (block) is high, count_o does not change on count edges. status_o bit 4 reads 1 one edge after bit 4 is sampled high.
- R7: When ctrl_i bits 5 and 4 are both high, the load of R5 takes place and count_o equals preset_i.
- R8: aux_o[0] follows ctrl_i bit 2 and aux_o[1] follows ctrl_i bit 3, one clock edge later. status_o bits 2 and 3 always equal aux_o[0] and aux_o[1].
- R9: status_o bit 1 is the synchronised dir_in_i level and status_o bit 0 is the synchronised cnt_in_i level, each valid two edges after the input changes. status_o bits 7 and 6 are always 0.
- R10: ctrl_i bits 7, 6, 1 and 0 have no effect on count_o, aux_o or status_o.
- R11: With INVERT_DIR set to 1, a high direction level decrements and a low level increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_in_i | input | 1 | Asynchronous count pulse input |
| dir_in_i | input | 1 | Asynchronous direction level |
| ctrl_i | input | 8 | Control byte: bit 5 set, bit 4 block, bit 3 second aux output, bit 2 first aux output |
| preset_i | input | CNT_W | Preset value loaded while set is high |
| status_o | output | 8 | Status byte: bit 5 set ack, bit 4 blocked, bits 3:2 aux echo, bit 1 direction level, bit 0 count level |
| count_o | output | CNT_W | Current count, plain binary |
| aux_o | output | 2 | Auxiliary digital outputs |

## Verification
On every cycle the assertions check the following:
- the load while set is high;
- the freeze while block is high;
- the one-step limit on any count change while counting is free;
- the one-cycle follow of the aux outputs and their echo in the status byte;
- the zero upper status bits.

Only the bench scenarios can show the rest:
- that edges are counted in the direction selected;
- that a held level counts once;
- that the wrap happens in both directions;
- that set has priority over block;
- that the ignored control bits are inert;
- that the inverted variant reverses direction.

// File: rtl/pulse_counter_pkg.sv
package pulse_counter_pkg;
  localparam int unsigned CTL_AUX0  = 2;
  localparam int unsigned CTL_AUX1  = 3;
  localparam int unsigned CTL_BLOCK = 4;
  localparam int unsigned CTL_SET   = 5;

  typedef struct packed {
    logic [1:0] zero;
    logic       set_ack;
    logic       blocked;
    logic       aux1;
    logic       aux0;
    logic       dir_lvl;
    logic       cnt_lvl;
  } status_t;
endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcnt_edge.sv
module pcnt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;
  logic rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      rise_q <= lvl_i & ~prev_q;
    end
  end

  assign rise_o = rise_q;
endmodule

// File: rtl/pcnt_core.sv
module pcnt_core #(
  parameter int unsigned CNT_W      = 32,
  parameter bit          INVERT_DIR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             load_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] count_o
);
  logic             up;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  if (INVERT_DIR) begin : g_inv
    assign up = ~dir_i;
  end else begin : g_norm
    assign up = dir_i;
  end

  always_comb begin
    count_d = count_q;
    if (load_i)               count_d = preset_i;
    else if (!hold_i && step_i)
      count_d = up ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pulse_counter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ctrl_i,
  input  logic       dir_lvl_i,
  input  logic       cnt_lvl_i,
  output logic       load_o,
  output logic       hold_o,
  output logic [1:0] aux_o,
  output logic [7:0] status_o
);
  logic       set_q;
  logic       block_q;
  logic [1:0] aux_q;
  status_t    st;
  logic       unused_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q   <= 1'b0;
      block_q <= 1'b0;
      aux_q   <= '0;
    end else begin
      set_q   <= ctrl_i[CTL_SET];
      block_q <= ctrl_i[CTL_BLOCK];
      aux_q   <= {ctrl_i[CTL_AUX1], ctrl_i[CTL_AUX0]};
    end
  end

  // set outranks block inside the core; both act on the live control byte
  assign load_o = ctrl_i[CTL_SET];
  assign hold_o = ctrl_i[CTL_BLOCK];
  assign aux_o  = aux_q;

  always_comb begin
    st         = '0;
    st.set_ack = set_q;
    st.blocked = block_q;
    st.aux1    = aux_q[1];
    st.aux0    = aux_q[0];
    st.dir_lvl = dir_lvl_i;
    st.cnt_lvl = cnt_lvl_i;
  end

  assign status_o    = st;
  assign unused_ctrl = ^{ctrl_i[7:6], ctrl_i[1:0]};
endmodule

// File: rtl/pulse_counter.sv
module pulse_counter #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          INVERT_DIR  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_in_i,
  input  logic             dir_in_i,
  input  logic [7:0]       ctrl_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [7:0]       status_o,
  output logic [CNT_W-1:0] count_o,
  output logic [1:0]       aux_o
);
  logic [1:0] lvl_s;
  logic       step;
  logic       load;
  logic       hold;

  pcnt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dir_in_i, cnt_in_i}),
    .q_o   (lvl_s)
  );

  pcnt_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_s[0]),
    .rise_o(step)
  );

  pcnt_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_i   (ctrl_i),
    .dir_lvl_i(lvl_s[1]),
    .cnt_lvl_i(lvl_s[0]),
    .load_o   (load),
    .hold_o   (hold),
    .aux_o    (aux_o),
    .status_o (status_o)
  );

  pcnt_core #(.CNT_W(CNT_W), .INVERT_DIR(INVERT_DIR)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .dir_i   (lvl_s[1]),
    .load_i  (load),
    .hold_i  (hold),
    .preset_i(preset_i),
    .count_o (count_o)
  );
endmodule

// File: rtl/pulse_counter_chk.sv
module pulse_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       ctrl_i,
  input logic [CNT_W-1:0] preset_i,
  input logic [7:0]       status_o,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       aux_o
);
  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[5] |=> (count_o == $past(preset_i)) && status_o[5]);

  assert_block_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[4] && !ctrl_i[5]) |=> (count_o == $past(count_o)) && status_o[4]);

  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[5] && !ctrl_i[4]) |=>
      (count_o == $past(count_o)) ||
      (count_o == $past(count_o) + CNT_W'(1)) ||
      (count_o == $past(count_o) - CNT_W'(1)));

  assert_aux_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> aux_o == $past(ctrl_i[3:2]));

  assert_aux_echo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3:2] == aux_o);

  assert_top_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:6] == 2'b00);
endmodule

bind pulse_counter pulse_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctrl_i  (ctrl_i),
  .preset_i(preset_i),
  .status_o(status_o),
  .count_o (count_o),
  .aux_o   (aux_o)
);

// File: tb/pulse_counter_tb.sv
`timescale 1ns/1ps
module pulse_counter_tb;
  localparam int unsigned CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cnt_in = 1'b0;
  logic             dir_in = 1'b0;
  logic [7:0]       ctrl = 8'h00;
  logic [CNT_W-1:0] preset = '0;
  logic [7:0]       status, status_inv;
  logic [CNT_W-1:0] count, count_inv;
  logic [1:0]       aux, aux_inv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_counter #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_in_i(cnt_in), .dir_in_i(dir_in),
    .ctrl_i(ctrl), .preset_i(preset), .status_o(status), .count_o(count), .aux_o(aux)
  );

  pulse_counter #(.CNT_W(CNT_W), .INVERT_DIR(1'b1)) u_dut_inv (
    .clk_i(clk), .rst_ni(rst_n), .cnt_in_i(cnt_in), .dir_in_i(dir_in),
    .ctrl_i(ctrl), .preset_i(preset), .status_o(status_inv), .count_o(count_inv),
    .aux_o(aux_inv)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic pulse(input int high_cycles);
    cnt_in = 1'b1;
    tick(high_cycles);
    cnt_in = 1'b0;
    tick(3);
  endtask

  task automatic load(input logic [31:0] v);
    preset = v;
    ctrl = 8'h20;
    tick(1);
    ctrl = 8'h00;
    tick(1);
  endtask

  task automatic set_dir(input logic d);
    dir_in = d;
    tick(3);
  endtask

  task automatic t_reset;
    check(count == 0, "R1", count, 0);
    check(status == 8'h00, "R1", status, 0);
    check(aux == 2'b00, "R1", aux, 0);
  endtask

  task automatic t_set_hold;
    preset = 32'hA5A5_0001;
    ctrl = 8'h20;
    tick(1);
    check(count == 32'hA5A5_0001, "R5", count, 32'hA5A5_0001);
    check(status[5] == 1'b1, "R5", status, 8'h20);
    set_dir(1'b1);
    pulse(3);
    check(count == 32'hA5A5_0001, "R5", count, 32'hA5A5_0001);
    ctrl = 8'h00;
    tick(1);
    check(status[5] == 1'b0, "R5", status, 0);
  endtask

  task automatic t_count_up;
    load(0);
    set_dir(1'b1);
    check(status[1] == 1'b1, "R9", status, 8'h02);
    for (int i = 0; i < 3; i++) pulse(3);
    check(count == 3, "R2", count, 3);
    check(count_inv == 32'hFFFF_FFFD, "R11", count_inv, 32'hFFFF_FFFD);
    pulse(12);
    check(count == 4, "R2", count, 4);
  endtask

  task automatic t_count_down;
    set_dir(1'b0);
    check(status[1] == 1'b0, "R9", status, 0);
    pulse(3);
    pulse(3);
    check(count == 2, "R3", count, 2);
    check(count_inv == 32'hFFFF_FFFE, "R11", count_inv, 32'hFFFF_FFFE);
    load(0);
    pulse(3);
    check(count == 32'hFFFF_FFFF, "R3", count, 32'hFFFF_FFFF);
  endtask

  task automatic t_wrap_up;
    load(32'hFFFF_FFFF);
    set_dir(1'b1);
    pulse(3);
    check(count == 0, "R4", count, 0);
    pulse(3);
    check(count == 1, "R4", count, 1);
  endtask

  task automatic t_block;
    load(32'h0000_0010);
    set_dir(1'b1);
    ctrl = 8'h10;
    tick(1);
    check(status == 8'h12, "R6", status, 8'h12);
    pulse(3);
    pulse(3);
    check(count == 32'h10, "R6", count, 32'h10);
    ctrl = 8'h00;
    tick(1);
    pulse(3);
    check(count == 32'h11, "R6", count, 32'h11);
  endtask

  task automatic t_priority;
    preset = 32'h0000_1234;
    ctrl = 8'h30;
    tick(1);
    check(count == 32'h1234, "R7", count, 32'h1234);
    pulse(3);
    check(count == 32'h1234, "R7", count, 32'h1234);
    ctrl = 8'h00;
    tick(1);
  endtask

  task automatic t_aux;
    ctrl = 8'h04;
    tick(1);
    check(aux == 2'b01, "R8", aux, 1);
    check(status[3:2] == 2'b01, "R8", status, 8'h04);
    ctrl = 8'h08;
    tick(1);
    check(aux == 2'b10, "R8", aux, 2);
    check(status[3:2] == 2'b10, "R8", status, 8'h08);
    ctrl = 8'h00;
    tick(1);
  endtask

  task automatic t_ignored;
    load(32'h0000_0100);
    set_dir(1'b1);
    ctrl = 8'hC3;
    tick(1);
    check(aux == 2'b00, "R10", aux, 0);
    check(status == 8'h02, "R10", status, 8'h02);
    pulse(3);
    check(count == 32'h101, "R10", count, 32'h101);
    ctrl = 8'h00;
    tick(1);
  endtask

  task automatic t_live;
    cnt_in = 1'b1;
    tick(2);
    check(status[0] == 1'b1, "R9", status, 8'h03);
    check(status[7:6] == 2'b00, "R9", status, 0);
    cnt_in = 1'b0;
    tick(2);
    check(status[0] == 1'b0, "R9", status, 8'h02);
    tick(2);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_set_hold();
    t_count_up();
    t_count_down();
    t_wrap_up();
    t_block();
    t_priority();
    t_aux();
    t_ignored();
    t_live();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule